// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial configuration EEPROM. It drives chip select, serial clock and serial data toward the device, and samples the device's data output. A host places a word address on the address input and pulses start. The block then runs one read transaction: it raises chip select, shifts out a read opcode and the address, clocks in sixteen data bits, releases the device and gives one trailing clock pulse. It then pulses done and presents the word.

The serial clock is deliberately slow. Every high and low level lasts a fixed minimum time, and the data line is set up a short time before each rising clock edge. Both durations are given in nanoseconds and turned into cycle counts from the system clock frequency, rounding up, so the block meets the device timing at any clock rate.

A checksum mode reads every word address of the device in order, from 0 to the last one. It adds the words with 16-bit wraparound and compares the total with a signature fixed at build time. The total is returned on the data output, and a match flag comes with done. A start request that arrives during a transaction is dropped.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, chip select, serial clock, serial data-in, done, busy and the match flag are all 0.
- R2: Chip select rises at least one setup time before the first rising serial clock edge. It stays high through all 25 pulses of a read: 3 opcode bits, 6 address bits and 16 data bits.
- R3: The block shifts out the 3-bit read opcode 110, followed by the 6-bit word address, each most significant bit first. Data-in never changes in the cycle in which the serial clock rises.
- R4: Every serial clock high level and every low level inside a transaction lasts at least ceil(9000 ns × CLK_FREQ_HZ / 1e9) system clock cycles.
- R5: The block samples sixteen data bits at the end of each clock-high level, most significant bit first, and returns them on rd_data.
- R6: After the last data bit, chip select and data-in fall together. Exactly one further full serial clock pulse then follows with chip select low, and done comes after that pulse.
- R7: Done is high for exactly one cycle per transaction. rd_data and csum_ok hold their values until the next accepted start.
- R8: A start pulse while busy is high has no effect. It changes neither the address read nor the result, and it adds no done pulse.
- R9: With csum_mode high at start, the block reads addresses 0 to 63 in order and returns their sum modulo 2^16 on rd_data. It sets csum_ok only when that sum equals SIGNATURE.
- R10: Data-in is 0 throughout the data phase and the trailing pulse. In a plain read, csum_ok stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (single-cycle pulse) |
| addr | input | ADDR_W | Word address for a plain read |
| csum_mode | input | 1 | Select the whole-device checksum at start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word read, or the checksum total |
| csum_ok | output | 1 | Checksum total equals SIGNATURE |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest conditions to reach are a start request that lands in the middle of a transaction and a checksum that fails only because of one bit. The bench handles the first by raising start again, with a different address and checksum mode set, while the serial clock is shifting the address of an earlier read. The behavioural EEPROM model then has to report only the first address, and the monitor has to count exactly one done pulse. For the second, a full checksum pass is run against the untouched model contents and must match. One bit of one word is then flipped, and the run must return the new total with the match flag cleared, because a single-bit difference in 64 words shows nowhere else at the ports.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [3:0] {
      E_IDLE,   // waiting for a launch
      E_CSU,    // chip select setup before the first bit
      E_DSET,   // command bit presented, setup before rise
      E_CHI,    // command clock high
      E_CLO,    // command clock low
      E_DHOLD,  // data-in released after the address
      E_RHI,    // data clock high, sample at the end
      E_RLO,    // data clock low
      E_TCS,    // chip select dropped, gap before tail pulse
      E_THI,    // tail clock high
      E_TLO     // tail clock low
   } eng_st_t;

   function automatic int ns_to_cycles(longint freq_hz, longint ns);
      longint c;
      c = (freq_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      return (c < 1) ? 1 : int'(c);
   endfunction
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= len - 1'b1;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mw_word_engine.sv
module mw_word_engine
   import mw_pkg::*;
#(
   parameter int          ADDR_W    = 6,
   parameter int          OPC_W     = 3,
   parameter logic [OPC_W-1:0] OPC_READ = 3'b110,
   parameter int          DATA_W    = 16,
   parameter int          PHASE_CYC = 9,
   parameter int          SETUP_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ee_do,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   output logic [DATA_W-1:0] word,
   output logic              word_valid
);
   localparam int CMD_W   = OPC_W + ADDR_W;
   localparam int MAXC    = (PHASE_CYC > SETUP_CYC) ? PHASE_CYC : SETUP_CYC;
   localparam int CNT_W   = $clog2(MAXC + 1);
   localparam int MAXB    = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int BC_W    = (MAXB > 1) ? $clog2(MAXB) : 1;
   localparam logic [CNT_W-1:0] L_PHASE = CNT_W'(PHASE_CYC);
   localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC);

   eng_st_t          st;
   logic [CMD_W-1:0] sreg;
   logic [BC_W-1:0]  bitcnt;
   logic             t_exp, t_load;
   logic [CNT_W-1:0] t_len;
   logic             adv;

   mw_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp));

   assign adv = (st == E_IDLE) ? go : t_exp;

   always_comb begin
      t_load = adv && (st != E_TLO);
      unique case (st)
         E_IDLE, E_CSU, E_CLO, E_TCS: t_len = (st == E_TCS) ? L_PHASE : L_SETUP;
         E_RLO:   t_len = (bitcnt == '0) ? L_SETUP : L_PHASE;
         default: t_len = L_PHASE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; sreg <= '0; bitcnt <= '0; word <= '0;
         ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0; word_valid <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (adv) begin
            unique case (st)
               E_IDLE: begin
                  ee_cs <= 1'b1; ee_di <= 1'b0; ee_sk <= 1'b0;
                  sreg <= {OPC_READ, addr}; bitcnt <= BC_W'(CMD_W - 1);
                  word <= '0; st <= E_CSU;
               end
               E_CSU: begin
                  ee_di <= sreg[CMD_W-1]; sreg <= sreg << 1; st <= E_DSET;
               end
               E_DSET: begin ee_sk <= 1'b1; st <= E_CHI; end
               E_CHI:  begin ee_sk <= 1'b0; st <= E_CLO; end
               E_CLO: begin
                  if (bitcnt == '0) begin
                     ee_di <= 1'b0; st <= E_DHOLD;
                  end else begin
                     bitcnt <= bitcnt - 1'b1;
                     ee_di <= sreg[CMD_W-1]; sreg <= sreg << 1; st <= E_DSET;
                  end
               end
               E_DHOLD: begin
                  ee_sk <= 1'b1; bitcnt <= BC_W'(DATA_W - 1); st <= E_RHI;
               end
               E_RHI: begin
                  word <= {word[DATA_W-2:0], ee_do}; ee_sk <= 1'b0; st <= E_RLO;
               end
               E_RLO: begin
                  if (bitcnt == '0) begin
                     ee_cs <= 1'b0; ee_di <= 1'b0; st <= E_TCS;
                  end else begin
                     bitcnt <= bitcnt - 1'b1; ee_sk <= 1'b1; st <= E_RHI;
                  end
               end
               E_TCS: begin ee_sk <= 1'b1; st <= E_THI; end
               E_THI: begin ee_sk <= 1'b0; st <= E_TLO; end
               E_TLO: begin word_valid <= 1'b1; st <= E_IDLE; end
               default: st <= E_IDLE;
            endcase
         end
      end
   end

   // high-level length monitor for the serial clock
   logic             sk_q;
   logic [CNT_W:0]   lvl_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_q <= 1'b0; lvl_cnt <= '0;
      end else begin
         sk_q <= ee_sk;
         if (ee_sk != sk_q)      lvl_cnt <= 1;
         else if (!(&lvl_cnt))   lvl_cnt <= lvl_cnt + 1'b1;
      end
   end

   a_r4_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (sk_q && !ee_sk) |-> (lvl_cnt >= (CNT_W+1)'(PHASE_CYC)));
   a_r3_di_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_sk) |-> $stable(ee_di));
   a_r2_cs_during_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_CHI || st == E_RHI || st == E_DSET) |-> ee_cs);
   a_r10_di_low_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_RHI || st == E_RLO || st == E_THI || st == E_TLO) |-> !ee_di);
   a_r6_cs_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> (!ee_di && !ee_sk));
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
   import mw_pkg::*;
#(
   parameter longint            CLK_FREQ_HZ = 50_000_000,
   parameter int                PHASE_NS    = 9000,
   parameter int                SETUP_NS    = 400,
   parameter int                ADDR_W      = 6,
   parameter int                OPC_W       = 3,
   parameter logic [OPC_W-1:0]  OPC_READ    = 3'b110,
   parameter bit                CSUM_EN     = 1'b1,
   parameter logic [15:0]       SIGNATURE   = 16'hBABA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              csum_mode,
   output logic              busy,
   output logic              done,
   output logic [15:0]       rd_data,
   output logic              csum_ok,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   localparam int DATA_W    = 16;
   localparam int PHASE_CYC = ns_to_cycles(CLK_FREQ_HZ, longint'(PHASE_NS));
   localparam int SETUP_CYC = ns_to_cycles(CLK_FREQ_HZ, longint'(SETUP_NS));
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (OPC_W < 1) begin : g_bad_opc
         $error("OPC_W must be positive");
      end
      if (CLK_FREQ_HZ < 1) begin : g_bad_clk
         $error("CLK_FREQ_HZ must be positive");
      end
   endgenerate

   logic              eng_go, eng_valid;
   logic [ADDR_W-1:0] eng_addr, idx;
   logic [DATA_W-1:0] eng_word, sum, sum_next;
   logic              csm, sig_hit;

   mw_word_engine #(
      .ADDR_W(ADDR_W), .OPC_W(OPC_W), .OPC_READ(OPC_READ), .DATA_W(DATA_W),
      .PHASE_CYC(PHASE_CYC), .SETUP_CYC(SETUP_CYC)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .go(eng_go), .addr(eng_addr), .ee_do(ee_do),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
      .word(eng_word), .word_valid(eng_valid));

   generate
      if (CSUM_EN) begin : g_csum
         assign sum_next = sum + eng_word;
         assign sig_hit  = (sum_next == SIGNATURE);
      end else begin : g_nocsum
         assign sum_next = eng_word;
         assign sig_hit  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; rd_data <= '0; csum_ok <= 1'b0;
         eng_go <= 1'b0; eng_addr <= '0; idx <= '0; sum <= '0; csm <= 1'b0;
      end else begin
         eng_go <= 1'b0;
         done   <= 1'b0;
         if (!busy && start) begin
            busy <= 1'b1; csm <= csum_mode & CSUM_EN;
            idx <= '0; sum <= '0; rd_data <= '0; csum_ok <= 1'b0;
            eng_addr <= (csum_mode & CSUM_EN) ? '0 : addr;
            eng_go <= 1'b1;
         end else if (busy && eng_valid) begin
            if (csm) begin
               sum <= sum_next;
               if (idx == LAST_ADDR) begin
                  busy <= 1'b0; done <= 1'b1;
                  rd_data <= sum_next; csum_ok <= sig_hit;
               end else begin
                  idx <= idx + 1'b1; eng_addr <= idx + 1'b1; eng_go <= 1'b1;
               end
            end else begin
               busy <= 1'b0; done <= 1'b1; rd_data <= eng_word;
            end
         end
      end
   end

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !(start && !busy)) |=> $stable(rd_data) || busy || done);
   a_r10_plain_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !csm) |-> !csum_ok);
   a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PHASE = 9;   // 9000 ns at 1 MHz, rounded up

   function automatic logic [15:0] pat(int a);
      return 16'((a * 16'h0F1D + 16'h3A5C) ^ (a << 9));
   endfunction
   function automatic logic [15:0] sig_of();
      logic [15:0] s = '0;
      for (int a = 0; a < 64; a++) s = s + pat(a);
      return s;
   endfunction
   localparam logic [15:0] SIG = sig_of();

   logic clk = 0, rst_n = 0, start = 0, csum_mode = 0;
   logic [5:0] addr = '0;
   logic busy, done, csum_ok, ee_cs, ee_sk, ee_di;
   logic [15:0] rd_data;
   logic ee_do = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mw_eeprom_reader #(.CLK_FREQ_HZ(1_000_000), .SIGNATURE(SIG)) u_mw_eeprom_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .csum_mode(csum_mode),
      .busy(busy), .done(done), .rd_data(rd_data), .csum_ok(csum_ok),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

   // behavioural EEPROM
   logic [15:0] mem [64];
   int bitn, tail_rises, didx, addr_seen_cnt;
   logic [8:0] cmd;
   logic [15:0] cur;
   int seen_addr [64];
   initial for (int a = 0; a < 64; a++) mem[a] = pat(a);

   always @(posedge ee_cs) begin bitn = 0; tail_rises = 0; end
   always @(posedge ee_sk) begin
      if (ee_cs) begin
         bitn++;
         if (bitn <= 9) cmd = {cmd[7:0], ee_di};
         if (bitn == 9) begin
            cur = mem[cmd[5:0]]; ee_do <= cur[15]; didx = 14;
            seen_addr[addr_seen_cnt % 64] = int'(cmd[5:0]); addr_seen_cnt++;
         end
      end else tail_rises++;
   end
   always @(negedge ee_sk) begin
      if (ee_cs && bitn > 9 && didx >= 0) begin ee_do <= cur[didx]; didx--; end
   end

   // monitors
   int done_cnt, hi_run, hi_min;
   bit cs_at_done;
   always @(negedge clk) begin
      if (done) begin done_cnt++; cs_at_done = ee_cs; end
      if (ee_sk) hi_run++;
      else if (hi_run > 0) begin if (hi_run < hi_min) hi_min = hi_run; hi_run = 0; end
   end

   int checks = 0, fails = 0;
   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   task automatic pulse_start(logic [5:0] a, logic cm);
      @(negedge clk); addr = a; csum_mode = cm; start = 1;
      @(negedge clk); start = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!ee_cs && !ee_sk && !ee_di, "R1 pins", {ee_cs, ee_sk, ee_di}, 0);
      chk(!done && !busy && !csum_ok, "R1 flags", {done, busy, csum_ok}, 0);
   endtask

   task automatic t_read(logic [5:0] a);
      bit ok;
      done_cnt = 0; hi_min = 1000; addr_seen_cnt = 0;
      pulse_start(a, 0);
      wait_done(ok);
      chk(ok, "R7 done seen", ok, 1);
      chk(rd_data == mem[a], "R5 word", rd_data, mem[a]);
      chk(cmd[8:6] == 3'b110, "R3 opcode", cmd[8:6], 3'b110);
      chk(cmd[5:0] == a, "R3 address", cmd[5:0], a);
      chk(bitn == 25, "R2 pulses under cs", bitn, 25);
      chk(tail_rises == 1 && !cs_at_done, "R6 tail pulse", tail_rises, 1);
      chk(hi_min >= PHASE, "R4 high level", hi_min, PHASE);
      chk(!csum_ok, "R10 no match in read", csum_ok, 0);
      repeat (3) @(negedge clk);
      chk(done_cnt == 1, "R7 single done", done_cnt, 1);
   endtask

   task automatic t_hold();
      logic [15:0] v;
      v = rd_data;
      @(negedge clk); addr = 6'd11;
      repeat (200) @(negedge clk);
      chk(rd_data == v && !done, "R7 held", rd_data, v);
   endtask

   task automatic t_busy_start();
      bit ok;
      done_cnt = 0; addr_seen_cnt = 0;
      pulse_start(6'd5, 0);
      repeat (100) @(negedge clk);
      pulse_start(6'd40, 1);
      wait_done(ok);
      chk(rd_data == mem[5], "R8 result kept", rd_data, mem[5]);
      repeat (1500) @(negedge clk);
      chk(done_cnt == 1, "R8 no extra done", done_cnt, 1);
      chk(addr_seen_cnt == 1 && seen_addr[0] == 5, "R8 address kept", seen_addr[0], 5);
      chk(!busy, "R8 idle after", busy, 0);
   endtask

   task automatic t_csum(bit corrupt);
      bit ok;
      logic [15:0] exp = '0;
      if (corrupt) mem[17] = mem[17] ^ 16'h0100;
      for (int a = 0; a < 64; a++) exp = exp + mem[a];
      done_cnt = 0; addr_seen_cnt = 0;
      pulse_start(6'd9, 1);
      wait_done(ok);
      chk(ok, "R9 done", ok, 1);
      chk(rd_data == exp, "R9 sum", rd_data, exp);
      chk(csum_ok == !corrupt, "R9 match flag", csum_ok, !corrupt);
      chk(addr_seen_cnt == 64 && seen_addr[63] == 63 && seen_addr[0] == 0,
          "R9 address order", seen_addr[63], 63);
      repeat (5) @(negedge clk);
      chk(csum_ok == !corrupt && done_cnt == 1, "R7 flag held", csum_ok, !corrupt);
      if (corrupt) mem[17] = mem[17] ^ 16'h0100;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      hi_min = 1000;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      repeat (2) @(negedge clk);
      t_read(6'd0);
      t_read(6'd63);
      t_read(6'd42);
      t_hold();
      t_busy_start();
      t_csum(0);
      t_csum(1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule